// File: doc/BRIEF.md
# Strobe-Qualified Host Bus Cycle Interface

This block is the host-facing front end of a content-addressable memory. A host frames each access with an active-low chip-enable strobe. While the strobe is low, the host also holds an active-low write select, an active-low command/data select and an active-low chain-enable input. The block brings the strobe and these controls into the system clock domain through two-flop synchronizers and detects both strobe edges there. On the falling edge it latches the controls and raises exactly one of four one-clock cycle-type pulses. On the rising edge it advances the destination and source segment counters, freezes the chain-enable state of the access that just ended, and releases the bus.

The 16-bit data bus is split into an input, an output and an output enable, so that the pad ring can build the tri-state driver. The enable is raised only for read accesses, and the block drives the read data that downstream logic supplies. On a write access, the bus value is captured on the clock that sees the strobe rise, and a one-clock capture pulse accompanies it.

Top module: `strobe_bus_front`

## Requirements
- R1: While the synchronous active-low reset is low at a clock edge, the block sets all of these to 0 after that edge: the cycle pulses, the bus enable, the bus output, the write capture pulse and its data, both segment counters and the frozen chain state. The control latches return to their idle-high state.
- R2: The strobe and the three controls each pass through two flops. If the strobe falls before clock edge E, the cycle-type pulse is high from edge E+2 to edge E+3, which is one clock only.
- R3: The controls are decoded as they stand in the synchronizer when the strobe's falling edge is detected. The pulse output `cyc_type` uses these bits: bit 0 = command write (write select low, command select low), bit 1 = data write (write low, command high), bit 2 = command read (write high, command low), bit 3 = data read (write high, command high).
- R4: `cyc_type` is one-hot in the clock after a detected falling edge and all zero in every other clock.
- R5: `bus_oe` rises in the clock after the falling edge of a read access. It falls in the clock after the rising edge is detected. `bus_out` equals `rd_data` while `bus_oe` is high and is 0 otherwise. `bus_oe` never rises during a write access.
- R6: Every detected rising edge of the strobe increments both segment counters by one, and the counters change at no other time.
- R7: When the strobe's rising edge is detected during a write access, the next clock holds `bus_in` in `wr_data` and sets `wr_pulse` high for exactly one clock. Read accesses do not change `wr_data`.
- R8: The chain-enable input is latched on the falling edge. On the rising edge, `chain_hold` takes the inverse of that latched value (1 = chain enabled) and keeps it until the next rising edge.
- R9: Each 2-bit segment counter wraps from 3 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe_n | input | 1 | Asynchronous chip-enable strobe, active low |
| wr_n | input | 1 | Write select, low = write |
| cmd_n | input | 1 | Command select, low = command |
| chain_n | input | 1 | Chain enable, low = enabled |
| bus_in | input | 16 | Bus value seen at the pads |
| rd_data | input | 16 | Read data from downstream logic |
| bus_out | output | 16 | Value to drive onto the bus |
| bus_oe | output | 1 | Bus driver enable |
| cyc_type | output | 4 | One-clock cycle-type pulse, one-hot |
| wr_pulse | output | 1 | One-clock pulse marking a write capture |
| wr_data | output | 16 | Captured write value |
| dst_seg | output | 2 | Destination segment counter |
| src_seg | output | 2 | Source segment counter |
| chain_hold | output | 1 | Chain-enable state frozen at the last rising edge |

## Verification
The bench attacks these corner cases:
- Strobe pulses only one clock long and back-to-back accesses with a one-clock high gap. A detector that needs the strobe held longer would drop a cycle pulse or miss a counter advance.
- Four consecutive rising edges that take the counters through the 3-to-0 wrap. A design with a wrong width or a saturating counter would stick at 3.
- A write that follows a read. If the enable is left high, or is raised for writes, bus data appears where none belongs, and a read would corrupt `wr_data`.
- Control changes while the strobe is held low, and a reset in the middle of an access. A design that tracks the live controls instead of the latched ones would report the wrong cycle type or the wrong frozen chain state.

// File: rtl/strobe_bus_front.sv
module strobe_bus_front #(
  parameter int DW    = 16,
  parameter int SEG_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe_n,
  input  logic          wr_n,
  input  logic          cmd_n,
  input  logic          chain_n,
  input  logic [DW-1:0] bus_in,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic [3:0]    cyc_type,
  output logic          wr_pulse,
  output logic [DW-1:0] wr_data,
  output logic [SEG_W-1:0] dst_seg,
  output logic [SEG_W-1:0] src_seg,
  output logic          chain_hold
);

  localparam int NSIG = 4;

  logic [NSIG-1:0] meta, sync;
  logic            stb_prev;
  logic            wr_lat, cmd_lat, chain_lat;

  wire stb_s   = sync[0];
  wire wr_s    = sync[1];
  wire cmd_s   = sync[2];
  wire chain_s = sync[3];

  wire fall = stb_prev & ~stb_s;
  wire rise = ~stb_prev & stb_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta     <= '1;
      sync     <= '1;
      stb_prev <= 1'b1;
    end else begin
      meta     <= {chain_n, cmd_n, wr_n, strobe_n};
      sync     <= meta;
      stb_prev <= stb_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_lat    <= 1'b1;
      cmd_lat   <= 1'b1;
      chain_lat <= 1'b1;
      cyc_type  <= '0;
    end else begin
      cyc_type <= '0;
      if (fall) begin
        wr_lat    <= wr_s;
        cmd_lat   <= cmd_s;
        chain_lat <= chain_s;
        cyc_type[{wr_s, cmd_s}] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          bus_oe <= 1'b0;
    else if (rise)       bus_oe <= 1'b0;
    else if (fall && wr_s) bus_oe <= 1'b1;
  end

  assign bus_out = bus_oe ? rd_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_pulse   <= 1'b0;
      wr_data    <= '0;
      dst_seg    <= '0;
      src_seg    <= '0;
      chain_hold <= 1'b0;
    end else begin
      wr_pulse <= rise & ~wr_lat;
      if (rise) begin
        if (!wr_lat) wr_data <= bus_in;
        dst_seg    <= dst_seg + 1'b1;
        src_seg    <= src_seg + 1'b1;
        chain_hold <= ~chain_lat;
      end
    end
  end

  assert_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cyc_type));
  assert_pulse_after_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> $onehot(cyc_type));
  assert_no_pulse_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> cyc_type == '0);
  assert_oe_read_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> wr_lat);
  assert_oe_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !bus_oe);
  assert_seg_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> dst_seg == SEG_W'($past(dst_seg) + 1'b1));
  assert_seg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(dst_seg) && $stable(src_seg));
  assert_wr_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);

endmodule

// File: tb/test_strobe_bus_front.sv
module test_strobe_bus_front;
  logic clk = 0;
  always #5 clk = ~clk;

  logic rst_n = 0, strobe_n = 1, wr_n = 1, cmd_n = 1, chain_n = 1;
  logic [15:0] bus_in = 0, rd_data = 0;
  logic [15:0] bus_out, wr_data;
  logic bus_oe, wr_pulse, chain_hold;
  logic [3:0] cyc_type;
  logic [1:0] dst_seg, src_seg;

  strobe_bus_front i_strobe_bus_front (.*);

  int checks = 0, failures = 0;
  bit done = 0;

  // Behavioural model: history of sampled pin levels, decoded per edge.
  bit hs[$], hw[$], hc[$], hk[$];
  bit m_wr = 1, m_cmd = 1, m_ch = 1, m_oe = 0, m_wp = 0, m_hold = 0;
  int m_seg = 0;
  logic [15:0] m_wd = 0;
  logic [3:0] m_cyc = 0;

  always @(posedge clk) begin
    bit s_now, s_old, fall, rise;
    if (!rst_n) begin
      hs = {}; hw = {}; hc = {}; hk = {};
      repeat (4) begin hs.push_back(1); hw.push_back(1); hc.push_back(1); hk.push_back(1); end
      m_wr = 1; m_cmd = 1; m_ch = 1; m_oe = 0; m_wp = 0; m_hold = 0;
      m_seg = 0; m_wd = 0; m_cyc = 0;
    end else begin
      // level visible in the ending cycle is two samples old, previous is three
      s_now = hs[hs.size()-2]; s_old = hs[hs.size()-3];
      fall = s_old && !s_now; rise = !s_old && s_now;
      m_cyc = 0;
      m_wp = rise && !m_wr;
      if (rise) begin
        if (!m_wr) m_wd = bus_in;
        m_seg = (m_seg + 1) % 4;
        m_hold = !m_ch;
        m_oe = 0;
      end
      if (fall) begin
        m_wr  = hw[hw.size()-2];
        m_cmd = hc[hc.size()-2];
        m_ch  = hk[hk.size()-2];
        m_cyc[{m_wr, m_cmd}] = 1;
        if (m_wr) m_oe = 1;
      end
      hs.push_back(strobe_n); hw.push_back(wr_n); hc.push_back(cmd_n); hk.push_back(chain_n);
      if (hs.size() > 8) begin void'(hs.pop_front()); void'(hw.pop_front()); void'(hc.pop_front()); void'(hk.pop_front()); end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk("R3 cyc_type", {28'd0, cyc_type}, {28'd0, m_cyc});
    chk("R4 onehot", {31'd0, $countones(cyc_type) <= 1}, 32'd1);
    chk("R5 bus_oe", {31'd0, bus_oe}, {31'd0, m_oe});
    chk("R5 bus_out", {16'd0, bus_out}, {16'd0, m_oe ? rd_data : 16'd0});
    chk("R6 dst_seg", {30'd0, dst_seg}, m_seg);
    chk("R6 src_seg", {30'd0, src_seg}, m_seg);
    chk("R7 wr_pulse", {31'd0, wr_pulse}, {31'd0, m_wp});
    chk("R7 wr_data", {16'd0, wr_data}, {16'd0, m_wd});
    chk("R8 chain_hold", {31'd0, chain_hold}, {31'd0, m_hold});
  end

  task automatic access(bit w, bit c, bit k, logic [15:0] d, int lo, int hi);
    @(negedge clk);
    wr_n = w; cmd_n = c; chain_n = k; strobe_n = 0; bus_in = d; rd_data = ~d;
    repeat (lo) @(negedge clk);
    strobe_n = 1;
    wr_n = ~w; cmd_n = ~c; chain_n = ~k;
    repeat (hi) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset state", {bus_oe, cyc_type, wr_pulse, wr_data, dst_seg, src_seg, chain_hold}, 0);
    // R2 latency: strobe falls before edge E, pulse seen after E+2 only
    wr_n = 1; cmd_n = 1; chain_n = 0; strobe_n = 0;
    @(posedge clk); @(negedge clk);
    chk("R2 no pulse at E", {28'd0, cyc_type}, 0);
    @(negedge clk);
    chk("R2 no pulse at E+1", {28'd0, cyc_type}, 0);
    @(negedge clk);
    chk("R2 pulse at E+2", {28'd0, cyc_type}, 32'h8);
    @(negedge clk);
    chk("R2 pulse one clock", {28'd0, cyc_type}, 0);
    strobe_n = 1;
    repeat (5) @(negedge clk);
    access(0, 0, 1, 16'h1234, 4, 4);
    access(0, 1, 0, 16'hbeef, 5, 3);
    access(1, 0, 1, 16'h5555, 4, 4);
    access(1, 1, 0, 16'haaaa, 6, 4);
    chk("R9 wrap to 1 after five", {30'd0, dst_seg}, 32'd1);
    access(1, 1, 1, 16'h0f0f, 1, 1);
    access(0, 1, 0, 16'hc3c3, 1, 1);
    access(0, 0, 0, 16'h7777, 1, 1);
    repeat (6) @(negedge clk);
    for (int i = 0; i < 20; i++) access(i[0], i[1], i[2], 16'(i * 16'h1357), 1 + i % 3, 1 + i % 4);
    access(1, 1, 0, 16'h2222, 3, 0);
    strobe_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    strobe_n = 1;
    rst_n = 1;
    @(negedge clk);
    chk("R1 mid-access reset", {bus_oe, cyc_type, wr_pulse, wr_data, dst_seg, src_seg, chain_hold}, 0);
    access(0, 1, 1, 16'h9999, 3, 5);
    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule